// File: doc/BRIEF.md
# SPI FIFO Interrupt and Threshold Controller

This block produces the interrupt and status view that surrounds the transmit and receive FIFOs of an SPI controller. The FIFOs are represented only by their occupancy counters. Four strobes move those counters:

- software writing the transmit FIFO;
- the serial engine draining the transmit FIFO;
- the serial engine filling the receive FIFO;
- software reading the receive FIFO.

From the occupancy and two programmable thresholds, the block derives two level-driven interrupt sources:

- transmit-below-threshold;
- receive-above-threshold.

It also keeps three sticky error flags:

- transmit overflow;
- receive underflow;
- receive overflow.

A mask register selects which of the five sources drive the single interrupt line. Software sees a raw status (before masking) and a masked status.

The threshold registers keep a written value only when it is below the FIFO depth. Software can therefore find the depth by writing increasing values and reading them back. Clearing the controller enable flushes both FIFOs and drops the error flags. A dedicated clear strobe, issued when software reads the clear register, drops the error flags without touching the FIFOs.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: After reset, both fill levels, both thresholds, the mask and all three error flags are 0.
- R2: While enabled, a push adds one entry and a pop removes one entry. Each strobe is judged against the level at the start of the cycle. A push into a full FIFO is dropped, a pop from an empty FIFO removes nothing, and a pop from an empty transmit FIFO raises no flag.
- R3: Status bit 0 (transmit empty) is 1 while the transmit level is less than or equal to the transmit threshold.
- R4: Status bit 4 (receive full) is 1 while the receive level is strictly greater than the receive threshold, so a threshold of N needs N+1 entries.
- R5: Status bit 1 (transmit overflow) is set on the edge that sees a transmit push while the transmit level equals the depth, and it stays set.
- R6: Status bit 3 (receive overflow) is set on the edge that sees a receive push while the receive level equals the depth, and it stays set.
- R7: Status bit 2 (receive underflow) is set on the edge that sees a receive pop while the receive level is 0, and it stays set.
- R8: A clear strobe drops all three error flags on the next edge. A flag whose set condition occurs in the same cycle ends up set.
- R9: While the enable is low, both levels are forced to 0, the error flags are forced to 0, and pushes and pops have no effect.
- R10: A threshold write keeps the written value only if it is below the depth. Otherwise the old value remains.
- R11: The masked status is the raw status ANDed with the mask (1 enables a source). The interrupt output is 1 when any masked bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable; low flushes FIFOs and flags |
| tx_push_i | input | 1 | Software writes one transmit entry |
| tx_pop_i | input | 1 | Serial engine takes one transmit entry |
| rx_push_i | input | 1 | Serial engine stores one receive entry |
| rx_pop_i | input | 1 | Software reads one receive entry |
| clr_rd_i | input | 1 | Clear-register read, drops error flags |
| tx_thr_wr_i | input | 1 | Write strobe for the transmit threshold |
| rx_thr_wr_i | input | 1 | Write strobe for the receive threshold |
| thr_wdata_i | input | THR_W | Threshold write data |
| mask_wr_i | input | 1 | Write strobe for the mask |
| mask_wdata_i | input | 5 | Mask write data |
| tx_level_o | output | CNT_W | Transmit occupancy |
| rx_level_o | output | CNT_W | Receive occupancy |
| tx_thr_o | output | THR_W | Transmit threshold readback |
| rx_thr_o | output | THR_W | Receive threshold readback |
| mask_o | output | 5 | Mask readback |
| raw_stat_o | output | 5 | Status before masking |
| irq_stat_o | output | 5 | Status after masking |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench pushes into a full transmit FIFO, both alone and together with a pop. A design that let the pop make room would miss the overflow flag or count one entry too many.

It asks for a clear and an underflow in the same cycle. A design that let the clear win would lose the error.

It holds the receive level exactly at the threshold and then one above it, which catches an off-by-one in the full comparison.

It writes thresholds equal to and above the depth. A design that truncates the value instead of rejecting it would return a wrong readback.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int NUM_ERR = 3;
  // status bit positions
  localparam int SRC_TXE = 0;
  localparam int SRC_TXO = 1;
  localparam int SRC_RXU = 2;
  localparam int SRC_RXO = 3;
  localparam int SRC_RXF = 4;
endpackage

// File: rtl/spi_fifo_level.sv
module spi_fifo_level #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] level_o
);
  logic [CNT_W-1:0] level_q;
  logic             acc_push, acc_pop;

  assign acc_push = push_i && (level_q != CNT_W'(DEPTH));
  assign acc_pop  = pop_i && (level_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      level_q <= '0;
    else if (flush_i) level_q <= '0;
    else begin
      case ({acc_push, acc_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/spi_thr_reg.sv
module spi_thr_reg #(
  parameter int DEPTH = 16,
  parameter int THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [THR_W-1:0] wdata_i,
  output logic [THR_W-1:0] thr_o
);
  logic [THR_W-1:0] thr_q;
  logic             fits;

  // values at or above the depth are rejected so software can probe the depth
  assign fits = (32'(wdata_i) < DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           thr_q <= '0;
    else if (wr_i && fits) thr_q <= wdata_i;
  end

  assign thr_o = thr_q;
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import spi_fifo_irq_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int THR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tx_push_i,
  input  logic               tx_pop_i,
  input  logic               rx_push_i,
  input  logic               rx_pop_i,
  input  logic               clr_rd_i,
  input  logic               tx_thr_wr_i,
  input  logic               rx_thr_wr_i,
  input  logic [THR_W-1:0]   thr_wdata_i,
  input  logic               mask_wr_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  output logic [CNT_W-1:0]   tx_level_o,
  output logic [CNT_W-1:0]   rx_level_o,
  output logic [THR_W-1:0]   tx_thr_o,
  output logic [THR_W-1:0]   rx_thr_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] raw_stat_o,
  output logic [NUM_SRC-1:0] irq_stat_o,
  output logic               irq_o
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CNT_W-1:0]   tx_lvl, rx_lvl;
  logic [THR_W-1:0]   tx_thr, rx_thr;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_ERR-1:0] err_set, err_q;
  logic [CMP_W-1:0]   tx_lvl_x, rx_lvl_x, tx_thr_x, rx_thr_x;
  logic               flush;

  assign flush = !en_i;

  spi_fifo_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_lvl (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(tx_push_i & en_i), .pop_i(tx_pop_i & en_i), .level_o(tx_lvl));

  spi_fifo_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_lvl (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(rx_push_i & en_i), .pop_i(rx_pop_i & en_i), .level_o(rx_lvl));

  spi_thr_reg #(.DEPTH(DEPTH), .THR_W(THR_W)) u_tx_thr (
    .clk_i, .rst_ni, .wr_i(tx_thr_wr_i), .wdata_i(thr_wdata_i), .thr_o(tx_thr));

  spi_thr_reg #(.DEPTH(DEPTH), .THR_W(THR_W)) u_rx_thr (
    .clk_i, .rst_ni, .wr_i(rx_thr_wr_i), .wdata_i(thr_wdata_i), .thr_o(rx_thr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
  end

  // error conditions judged against start-of-cycle levels
  assign err_set[0] = en_i && tx_push_i && (tx_lvl == CNT_W'(DEPTH));
  assign err_set[1] = en_i && rx_pop_i  && (rx_lvl == '0);
  assign err_set[2] = en_i && rx_push_i && (rx_lvl == CNT_W'(DEPTH));

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         err_q[g] <= 1'b0;
      else if (!en_i)      err_q[g] <= 1'b0;
      else if (err_set[g]) err_q[g] <= 1'b1;  // set beats clear
      else if (clr_rd_i)   err_q[g] <= 1'b0;
    end
  end

  assign tx_lvl_x = CMP_W'(tx_lvl);
  assign rx_lvl_x = CMP_W'(rx_lvl);
  assign tx_thr_x = CMP_W'(tx_thr);
  assign rx_thr_x = CMP_W'(rx_thr);

  always_comb begin
    raw_stat_o          = '0;
    raw_stat_o[SRC_TXE] = (tx_lvl_x <= tx_thr_x);
    raw_stat_o[SRC_TXO] = err_q[0];
    raw_stat_o[SRC_RXU] = err_q[1];
    raw_stat_o[SRC_RXO] = err_q[2];
    raw_stat_o[SRC_RXF] = (rx_lvl_x > rx_thr_x);
  end

  assign irq_stat_o = raw_stat_o & mask_q;
  assign irq_o      = |irq_stat_o;
  assign tx_level_o = tx_lvl;
  assign rx_level_o = rx_lvl;
  assign tx_thr_o   = tx_thr;
  assign rx_thr_o   = rx_thr;
  assign mask_o     = mask_q;
endmodule

// File: rtl/spi_fifo_irq_ctrl_chk.sv
module spi_fifo_irq_ctrl_chk
  import spi_fifo_irq_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int THR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               tx_push_i,
  input logic               tx_pop_i,
  input logic               rx_push_i,
  input logic               rx_pop_i,
  input logic               clr_rd_i,
  input logic               tx_thr_wr_i,
  input logic               rx_thr_wr_i,
  input logic [THR_W-1:0]   thr_wdata_i,
  input logic               mask_wr_i,
  input logic [NUM_SRC-1:0] mask_wdata_i,
  input logic [CNT_W-1:0]   tx_level_o,
  input logic [CNT_W-1:0]   rx_level_o,
  input logic [THR_W-1:0]   tx_thr_o,
  input logic [THR_W-1:0]   rx_thr_o,
  input logic [NUM_SRC-1:0] mask_o,
  input logic [NUM_SRC-1:0] raw_stat_o,
  input logic [NUM_SRC-1:0] irq_stat_o,
  input logic               irq_o
);
  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(tx_level_o) <= DEPTH) && (32'(rx_level_o) <= DEPTH));

  a_r2_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tx_push_i && !tx_pop_i && (tx_level_o == CNT_W'(DEPTH))
    |=> tx_level_o == CNT_W'(DEPTH));

  a_r5_tx_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tx_push_i && (tx_level_o == CNT_W'(DEPTH)) |=> raw_stat_o[SRC_TXO]);

  a_r6_rx_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rx_push_i && (rx_level_o == CNT_W'(DEPTH)) |=> raw_stat_o[SRC_RXO]);

  a_r7_rx_udf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rx_pop_i && (rx_level_o == '0) |=> raw_stat_o[SRC_RXU]);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_rd_i && raw_stat_o[SRC_TXO] |=> raw_stat_o[SRC_TXO]);

  a_r9_disable_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tx_level_o == '0) && (rx_level_o == '0)
              && !raw_stat_o[SRC_TXO] && !raw_stat_o[SRC_RXU] && !raw_stat_o[SRC_RXO]);

  a_r10_thr_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_thr_wr_i && (32'(thr_wdata_i) >= DEPTH) |=> $stable(tx_thr_o));

  a_r11_masked_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '0) |-> !irq_o);

  a_r11_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stat_o & ~raw_stat_o) == '0);
endmodule

bind spi_fifo_irq_ctrl spi_fifo_irq_ctrl_chk #(.DEPTH(DEPTH), .THR_W(THR_W)) u_chk (.*);

// File: tb/spi_fifo_irq_ctrl_tb.sv
module spi_fifo_irq_ctrl_tb;
  localparam int DEPTH = 4;
  localparam int THR_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NV    = 27;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, tx_push_i = 1'b0, tx_pop_i = 1'b0, rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic clr_rd_i = 1'b0, tx_thr_wr_i = 1'b0, rx_thr_wr_i = 1'b0, mask_wr_i = 1'b0;
  logic [THR_W-1:0] thr_wdata_i = '0;
  logic [4:0] mask_wdata_i = '0;
  logic [CNT_W-1:0] tx_level_o, rx_level_o;
  logic [THR_W-1:0] tx_thr_o, rx_thr_o;
  logic [4:0] mask_o, raw_stat_o, irq_stat_o;
  logic irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  spi_fifo_irq_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W)) u_dut (.*);

  // {tx_push, tx_pop, rx_push, rx_pop, clr, en, exp tx level, exp rx level, exp raw}
  localparam logic [26:0] VECS [NV] = '{
    {6'b100001, 8'd1, 8'd0, 5'b00001},
    {6'b100001, 8'd2, 8'd0, 5'b00000},
    {6'b100001, 8'd3, 8'd0, 5'b00000},
    {6'b100001, 8'd4, 8'd0, 5'b00000},
    {6'b100001, 8'd4, 8'd0, 5'b00010},
    {6'b011001, 8'd3, 8'd1, 5'b00010},
    {6'b001001, 8'd3, 8'd2, 5'b10010},
    {6'b000011, 8'd3, 8'd2, 5'b10000},
    {6'b001001, 8'd3, 8'd3, 5'b10000},
    {6'b001001, 8'd3, 8'd4, 5'b10000},
    {6'b001001, 8'd3, 8'd4, 5'b11000},
    {6'b010111, 8'd2, 8'd3, 5'b10000},
    {6'b000101, 8'd2, 8'd2, 5'b10000},
    {6'b000101, 8'd2, 8'd1, 5'b00000},
    {6'b000101, 8'd2, 8'd0, 5'b00000},
    {6'b000101, 8'd2, 8'd0, 5'b00100},
    {6'b010001, 8'd1, 8'd0, 5'b00101},
    {6'b010001, 8'd0, 8'd0, 5'b00101},
    {6'b010001, 8'd0, 8'd0, 5'b00101},
    {6'b001111, 8'd0, 8'd1, 5'b00101},
    {6'b000000, 8'd0, 8'd0, 5'b00001},
    {6'b100000, 8'd0, 8'd0, 5'b00001},
    {6'b110001, 8'd1, 8'd0, 5'b00001},
    {6'b100001, 8'd2, 8'd0, 5'b00000},
    {6'b100001, 8'd3, 8'd0, 5'b00000},
    {6'b100001, 8'd4, 8'd0, 5'b00000},
    {6'b110001, 8'd3, 8'd0, 5'b00010}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_strobes();
    tx_push_i = 0; tx_pop_i = 0; rx_push_i = 0; rx_pop_i = 0; clr_rd_i = 0;
    tx_thr_wr_i = 0; rx_thr_wr_i = 0; mask_wr_i = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    check("R1 tx level", int'(tx_level_o), 0);
    check("R1 rx level", int'(rx_level_o), 0);
    check("R1 tx thr", int'(tx_thr_o), 0);
    check("R1 rx thr", int'(rx_thr_o), 0);
    check("R1 mask", int'(mask_o), 0);
    check("R1 raw (only tx empty)", int'(raw_stat_o), 1);
    check("R1 irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    thr_wdata_i = 8'd1; tx_thr_wr_i = 1; rx_thr_wr_i = 1;
    mask_wdata_i = 5'b11111; mask_wr_i = 1;
    step();
    clear_strobes();
    en_i = 1;
    step();

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      {tx_push_i, tx_pop_i, rx_push_i, rx_pop_i, clr_rd_i, en_i} = VECS[i][26:21];
      step();
      clear_strobes();
      check($sformatf("R2 tx level step %0d", i), int'(tx_level_o), int'(VECS[i][20:13]));
      check($sformatf("R2 rx level step %0d", i), int'(rx_level_o), int'(VECS[i][12:5]));
      check($sformatf("R3/R4/R5/R6/R7/R8/R9 raw step %0d", i), int'(raw_stat_o), int'(VECS[i][4:0]));
      check($sformatf("R11 irq step %0d", i), int'(irq_o), int'(|VECS[i][4:0]));
    end

    // R10 threshold retention
    thr_wdata_i = 8'd3; tx_thr_wr_i = 1; step(); clear_strobes();
    check("R10 tx thr below depth kept", int'(tx_thr_o), 3);
    thr_wdata_i = 8'd4; tx_thr_wr_i = 1; step(); clear_strobes();
    check("R10 tx thr equal depth rejected", int'(tx_thr_o), 3);
    thr_wdata_i = 8'd255; rx_thr_wr_i = 1; step(); clear_strobes();
    check("R10 rx thr above depth rejected", int'(rx_thr_o), 1);

    // R9 flush, then R11 masking
    en_i = 0; step();
    check("R9 flushed raw", int'(raw_stat_o), 1);
    mask_wdata_i = 5'b00000; mask_wr_i = 1; step(); clear_strobes();
    check("R11 no mask irq", int'(irq_o), 0);
    check("R11 no mask masked", int'(irq_stat_o), 0);
    mask_wdata_i = 5'b00001; mask_wr_i = 1; step(); clear_strobes();
    check("R11 tx empty enabled irq", int'(irq_o), 1);
    check("R11 masked view", int'(irq_stat_o), 1);
    mask_wdata_i = 5'b10000; mask_wr_i = 1; step(); clear_strobes();
    check("R11 other source only irq", int'(irq_o), 0);

    done = 1'b1;
    finish_run();
  end
endmodule